// File: doc/BRIEF.md
# UART FIFO DMA Request Generator

This block decides when a UART with 32-entry transmit and receive FIFOs asks a DMA controller for service. Each direction has two request lines. The single line asks for one element. The burst line asks for a block whose size is set by a per-direction watermark select. The block reads the fill level of each FIFO, the watermark selects, a global UART enable, a DMA enable for each direction, the DMA controller's busy indication, four receive error flags and an error-gating enable.

Every request is a register. Once a request rises, it stays high until the DMA controller reports that it is busy. While the controller is busy, no request can rise. After the busy indication drops, a request rises again only if its trigger still holds. The single and burst lines of one direction are independent, so both can be high in the same cycle. When error gating is on, any receive error forces both receive requests low. Transmit requests never see the error flags.

Top module: `uart_dma_req`

## Requirements
- R1: A synchronous active-high `rst` drives all four request outputs low at the next clock edge.
- R2: If `uart_en` is low, or the DMA enable for a direction is low, the requests of that direction are low after the next clock edge.
- R3: `tx_single` rises at the edge after a cycle in which the transmit FIFO has at least one empty location (`tx_level` < 32), the enables are high and `dma_busy` is low.
- R4: `rx_single` rises at the edge after a cycle in which `rx_level` is at least 1, under the same enable and busy conditions.
- R5: The watermark select is a 3-bit code: 0 = 1/8, 1 = 1/4, 2 = 1/2, 3 = 3/4, 4 = 7/8, and codes 5 to 7 act as 1/2. `tx_burst` needs at least 28, 24, 16, 8 or 4 empty locations for codes 0 to 4.
- R6: `rx_burst` needs at least 4, 8, 16, 24 or 28 filled entries for codes 0 to 4, with the code encoding given in R5.
- R7: The single and burst lines of a direction are independent, and both are high together when the fill level meets both triggers.
- R8: A request that is high stays high while `dma_busy` is low and the block is enabled, even if its trigger goes away.
- R9: A high `dma_busy` clears every request at the next edge, and no request rises while it stays high. A request can rise again at the edge after the first cycle in which `dma_busy` is low, if its trigger holds.
- R10: If `err_gate_en` is high and any bit of `rx_err` is set, both receive requests are low after the next edge. They stay low until all four bits are clear. The bits are [0] parity, [1] break, [2] framing, [3] overrun.
- R11: The transmit requests ignore `rx_err` and `err_gate_en`. When `err_gate_en` is low, `rx_err` has no effect on the receive requests either.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| uart_en | input | 1 | Global UART enable |
| tx_dma_en | input | 1 | DMA enable for the transmit direction |
| rx_dma_en | input | 1 | DMA enable for the receive direction |
| dma_busy | input | 1 | DMA controller busy; clears and blocks requests |
| err_gate_en | input | 1 | Receive errors suppress the receive requests when high |
| rx_err | input | 4 | Receive error flags: [0] parity, [1] break, [2] framing, [3] overrun |
| tx_level | input | 6 | Number of filled transmit FIFO entries (0 to 32) |
| rx_level | input | 6 | Number of filled receive FIFO entries (0 to 32) |
| tx_wm_sel | input | 3 | Transmit watermark code |
| rx_wm_sel | input | 3 | Receive watermark code |
| tx_single | output | 1 | Transmit single request |
| tx_burst | output | 1 | Transmit burst request |
| rx_single | output | 1 | Receive single request |
| rx_burst | output | 1 | Receive burst request |

## Verification
The bench drives each burst threshold one element below its trigger and then exactly at it, in both directions. It includes an out-of-range watermark code. An off-by-one comparison or a wrong code table shows up there as a burst that rises too early or never rises.

Other sequences cover the following cases:
- A trigger that disappears while a request is high. A design that tracks its trigger instead of holding the request drops the line early.
- A busy period held over several cycles. A design that lets new requests rise while busy is high is caught here.
- Error flags cleared one at a time. A design that releases the gate on the first cleared flag is caught here.
- An error that arrives while transmit is active. A design that gates transmit as well drops the transmit requests.

// File: rtl/uart_dreq_pkg.sv
package uart_dreq_pkg;

    // Which side of the UART a trigger unit serves
    typedef enum logic {
        DIR_TX = 1'b0,
        DIR_RX = 1'b1
    } dreq_dir_e;

    // Request pair of one direction
    typedef struct packed {
        logic burst;
        logic single;
    } dreq_pair_t;

    // Watermark code to eighths of the FIFO depth; codes above 4 act as half
    function automatic int unsigned wm_eighths(input logic [2:0] code);
        case (code)
            3'd0:    return 1;
            3'd1:    return 2;
            3'd2:    return 4;
            3'd3:    return 6;
            3'd4:    return 7;
            default: return 4;
        endcase
    endfunction

endpackage

// File: rtl/dreq_trigger.sv
module dreq_trigger
    import uart_dreq_pkg::*;
#(
    parameter int unsigned DEPTH = 32,
    parameter int unsigned LVL_W = $clog2(DEPTH + 1),
    parameter dreq_dir_e   DIR   = DIR_TX
) (
    input  logic [LVL_W-1:0] level,
    input  logic [2:0]       wm_sel,
    output dreq_pair_t       want
);
    localparam int unsigned      STEP    = DEPTH / 8;
    localparam logic [LVL_W-1:0] DEPTH_L = LVL_W'(DEPTH);

    logic [LVL_W-1:0] fill;
    logic [LVL_W-1:0] avail;
    logic [LVL_W-1:0] wm_part;
    logic [LVL_W-1:0] need;

    // Fill level clamped to the FIFO depth
    assign fill    = (level > DEPTH_L) ? DEPTH_L : level;
    assign wm_part = LVL_W'(STEP * wm_eighths(wm_sel));

    generate
        if (DIR == DIR_TX) begin : g_tx
            // Transmit side counts empty slots against the complement of the mark
            assign avail = DEPTH_L - fill;
            assign need  = DEPTH_L - wm_part;
        end else begin : g_rx
            // Receive side counts filled entries against the mark itself
            assign avail = fill;
            assign need  = wm_part;
        end
    endgenerate

    always_comb begin
        want.single = (avail != '0);
        want.burst  = (avail >= need);
    end

endmodule

// File: rtl/dreq_hold.sv
module dreq_hold (
    input  logic clk,
    input  logic rst,
    input  logic allow,
    input  logic busy,
    input  logic want,
    output logic req
);
    // Raise on the trigger, hold until busy, never raise during busy
    always_ff @(posedge clk) begin
        if (rst) begin
            req <= 1'b0;
        end else begin
            req <= allow & ~busy & (req | want);
        end
    end

endmodule

// File: rtl/uart_dma_req.sv
module uart_dma_req
    import uart_dreq_pkg::*;
#(
    parameter int unsigned DEPTH = 32,
    parameter int unsigned LVL_W = $clog2(DEPTH + 1)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             uart_en,
    input  logic             tx_dma_en,
    input  logic             rx_dma_en,
    input  logic             dma_busy,
    input  logic             err_gate_en,
    input  logic [3:0]       rx_err,
    input  logic [LVL_W-1:0] tx_level,
    input  logic [LVL_W-1:0] rx_level,
    input  logic [2:0]       tx_wm_sel,
    input  logic [2:0]       rx_wm_sel,
    output logic             tx_single,
    output logic             tx_burst,
    output logic             rx_single,
    output logic             rx_burst
);
    localparam int unsigned NREQ = 4;

    dreq_pair_t tx_want;
    dreq_pair_t rx_want;
    logic       rx_gated;
    logic       tx_allow;
    logic       rx_allow;

    logic [NREQ-1:0] want_vec;
    logic [NREQ-1:0] allow_vec;
    logic [NREQ-1:0] req_vec;

    dreq_trigger #(.DEPTH(DEPTH), .LVL_W(LVL_W), .DIR(DIR_TX)) u_tx_trig (
        .level  (tx_level),
        .wm_sel (tx_wm_sel),
        .want   (tx_want)
    );

    dreq_trigger #(.DEPTH(DEPTH), .LVL_W(LVL_W), .DIR(DIR_RX)) u_rx_trig (
        .level  (rx_level),
        .wm_sel (rx_wm_sel),
        .want   (rx_want)
    );

    assign rx_gated  = err_gate_en & (|rx_err);
    assign tx_allow  = uart_en & tx_dma_en;
    assign rx_allow  = uart_en & rx_dma_en & ~rx_gated;

    // Order: {rx_burst, rx_single, tx_burst, tx_single}
    assign want_vec  = {rx_want.burst, rx_want.single, tx_want.burst, tx_want.single};
    assign allow_vec = {rx_allow, rx_allow, tx_allow, tx_allow};

    generate
        for (genvar k = 0; k < NREQ; k++) begin : g_req
            dreq_hold u_hold (
                .clk   (clk),
                .rst   (rst),
                .allow (allow_vec[k]),
                .busy  (dma_busy),
                .want  (want_vec[k]),
                .req   (req_vec[k])
            );
        end
    endgenerate

    assign tx_single = req_vec[0];
    assign tx_burst  = req_vec[1];
    assign rx_single = req_vec[2];
    assign rx_burst  = req_vec[3];

endmodule

// File: rtl/uart_dma_req_chk.sv
module uart_dma_req_chk #(
    parameter int unsigned DEPTH = 32,
    parameter int unsigned LVL_W = $clog2(DEPTH + 1)
) (
    input logic             clk,
    input logic             rst,
    input logic             uart_en,
    input logic             tx_dma_en,
    input logic             rx_dma_en,
    input logic             dma_busy,
    input logic             err_gate_en,
    input logic [3:0]       rx_err,
    input logic [LVL_W-1:0] tx_level,
    input logic [LVL_W-1:0] rx_level,
    input logic             tx_single,
    input logic             tx_burst,
    input logic             rx_single,
    input logic             rx_burst
);
    localparam logic [LVL_W-1:0] DEPTH_L = LVL_W'(DEPTH);

    // R1
    a_r1_reset_clears: assert property (@(posedge clk)
        rst |=> {tx_single, tx_burst, rx_single, rx_burst} == 4'b0000);

    // R2
    a_r2_global_off: assert property (@(posedge clk) disable iff (rst)
        !uart_en |=> {tx_single, tx_burst, rx_single, rx_burst} == 4'b0000);

    // R2
    a_r2_tx_dir_off: assert property (@(posedge clk) disable iff (rst)
        !tx_dma_en |=> !tx_single && !tx_burst);

    // R3
    a_r3_tx_single_cause: assert property (@(posedge clk) disable iff (rst)
        $rose(tx_single) |-> $past(tx_level < DEPTH_L));

    // R4
    a_r4_rx_single_cause: assert property (@(posedge clk) disable iff (rst)
        $rose(rx_single) |-> $past(rx_level != '0));

    // R8
    a_r8_tx_hold: assert property (@(posedge clk) disable iff (rst)
        (tx_single && !dma_busy && uart_en && tx_dma_en) |=> tx_single);

    // R8
    a_r8_rx_hold: assert property (@(posedge clk) disable iff (rst)
        (rx_burst && !dma_busy && uart_en && rx_dma_en && !(err_gate_en && (|rx_err)))
        |=> rx_burst);

    // R9
    a_r9_busy_clears: assert property (@(posedge clk) disable iff (rst)
        dma_busy |=> {tx_single, tx_burst, rx_single, rx_burst} == 4'b0000);

    // R10
    a_r10_err_gate: assert property (@(posedge clk) disable iff (rst)
        (err_gate_en && (|rx_err)) |=> !rx_single && !rx_burst);

    // R11
    a_r11_tx_not_gated: assert property (@(posedge clk) disable iff (rst)
        (tx_single && !dma_busy && uart_en && tx_dma_en && (|rx_err)) |=> tx_single);

endmodule

bind uart_dma_req uart_dma_req_chk #(.DEPTH(DEPTH), .LVL_W(LVL_W)) u_chk (.*);

// File: tb/uart_dma_req_test.sv
`timescale 1ns/100ps
module uart_dma_req_test;

    logic       clk = 1'b0;
    logic       rst;
    logic       uart_en, tx_dma_en, rx_dma_en, dma_busy, err_gate_en;
    logic [3:0] rx_err;
    logic [5:0] tx_level, rx_level;
    logic [2:0] tx_wm_sel, rx_wm_sel;
    logic       tx_single, tx_burst, rx_single, rx_burst;

    typedef struct {
        logic [3:0] exp;   // {rx_burst, rx_single, tx_burst, tx_single}
        string      tag;
    } item_t;

    item_t sb_q[$];
    int    checks = 0;
    int    errors = 0;
    bit    done   = 1'b0;

    always #2.5 clk = ~clk;

    uart_dma_req uut (
        .clk         (clk),
        .rst         (rst),
        .uart_en     (uart_en),
        .tx_dma_en   (tx_dma_en),
        .rx_dma_en   (rx_dma_en),
        .dma_busy    (dma_busy),
        .err_gate_en (err_gate_en),
        .rx_err      (rx_err),
        .tx_level    (tx_level),
        .rx_level    (rx_level),
        .tx_wm_sel   (tx_wm_sel),
        .rx_wm_sel   (rx_wm_sel),
        .tx_single   (tx_single),
        .tx_burst    (tx_burst),
        .rx_single   (rx_single),
        .rx_burst    (rx_burst)
    );

    // Monitor: compare shortly after each rising edge
    initial begin
        forever begin
            @(posedge clk);
            #1;
            if (sb_q.size() != 0) begin
                item_t it;
                logic [3:0] got;
                it  = sb_q.pop_front();
                got = {rx_burst, rx_single, tx_burst, tx_single};
                checks++;
                if (got !== it.exp) begin
                    errors++;
                    $display("FAIL %s: got %b expected %b", it.tag, got, it.exp);
                end
            end
        end
    end

    // Driver: inputs were set at the falling edge; queue what the next edge must give
    task automatic cyc(input logic [3:0] exp, input string tag);
        item_t it;
        it.exp = exp;
        it.tag = tag;
        sb_q.push_back(it);
        @(posedge clk);
        @(negedge clk);
    endtask

    // Busy pulse clearing everything (R9)
    task automatic clear_busy();
        dma_busy = 1'b1;
        cyc(4'b0000, "R9 busy clears");
        dma_busy = 1'b0;
    endtask

    initial begin
        rst = 1'b1; uart_en = 1'b1; tx_dma_en = 1'b1; rx_dma_en = 1'b1;
        dma_busy = 1'b0; err_gate_en = 1'b0; rx_err = 4'b0000;
        tx_level = 6'd32; rx_level = 6'd0; tx_wm_sel = 3'd0; rx_wm_sel = 3'd0;
        @(negedge clk);
        rx_level = 6'd20;
        cyc(4'b0000, "R1 reset");
        cyc(4'b0000, "R1 reset held");
        rst = 1'b0; rx_level = 6'd0;
        cyc(4'b0000, "R3 R4 no trigger");

        rx_level = 6'd1;
        cyc(4'b0100, "R4 rx single");
        dma_busy = 1'b1;
        cyc(4'b0000, "R9 clear");
        dma_busy = 1'b0; rx_level = 6'd0;
        cyc(4'b0000, "R9 no trigger after busy");

        // R6 receive thresholds
        rx_level = 6'd3;
        cyc(4'b0100, "R6 rx code0 below");
        clear_busy();
        rx_level = 6'd4;
        cyc(4'b1100, "R6 R7 rx code0 at mark");
        clear_busy();
        rx_wm_sel = 3'd4; rx_level = 6'd27;
        cyc(4'b0100, "R6 rx code4 below");
        clear_busy();
        rx_level = 6'd28;
        cyc(4'b1100, "R6 rx code4 at mark");

        // R8 hold without trigger
        rx_level = 6'd0;
        cyc(4'b1100, "R8 hold");
        cyc(4'b1100, "R8 hold again");

        // R9 long busy
        dma_busy = 1'b1; rx_level = 6'd28;
        cyc(4'b0000, "R9 busy 1");
        cyc(4'b0000, "R9 busy 2");
        cyc(4'b0000, "R9 busy 3");
        dma_busy = 1'b0;
        cyc(4'b1100, "R9 reassert");

        // R10 gating, flags cleared one by one
        err_gate_en = 1'b1; rx_err = 4'b0100;
        cyc(4'b0000, "R10 framing gates");
        rx_err = 4'b0101;
        cyc(4'b0000, "R10 two flags");
        rx_err = 4'b0001;
        cyc(4'b0000, "R10 parity left");
        rx_err = 4'b0000;
        cyc(4'b1100, "R10 released");

        // R11 transmit not gated, gate disabled ignores errors
        rx_err = 4'b1000;
        tx_level = 6'd0;
        cyc(4'b0011, "R11 tx with overrun");
        err_gate_en = 1'b0;
        cyc(4'b1111, "R11 gate off");
        rx_err = 4'b0000;
        dma_busy = 1'b1; rx_level = 6'd0; tx_level = 6'd32;
        cyc(4'b0000, "R9 clear all");
        dma_busy = 1'b0;
        cyc(4'b0000, "R3 full fifo");

        // R5 transmit thresholds
        tx_wm_sel = 3'd2; tx_level = 6'd17;
        cyc(4'b0001, "R5 tx code2 below");
        clear_busy();
        tx_level = 6'd16;
        cyc(4'b0011, "R5 tx code2 at mark");
        clear_busy();
        tx_wm_sel = 3'd6; tx_level = 6'd17;
        cyc(4'b0001, "R5 tx code6 below");
        clear_busy();
        tx_level = 6'd16;
        cyc(4'b0011, "R5 tx code6 at mark");
        clear_busy();
        tx_wm_sel = 3'd4; tx_level = 6'd29;
        cyc(4'b0001, "R5 tx code4 below");
        clear_busy();
        tx_level = 6'd28;
        cyc(4'b0011, "R5 tx code4 at mark");

        // R2 enables
        tx_dma_en = 1'b0;
        cyc(4'b0000, "R2 tx dma off");
        tx_dma_en = 1'b1;
        cyc(4'b0011, "R2 tx dma on");
        rx_dma_en = 1'b0; rx_level = 6'd28;
        cyc(4'b0011, "R2 rx dma off");
        rx_dma_en = 1'b1;
        cyc(4'b1111, "R2 rx dma on");
        uart_en = 1'b0;
        cyc(4'b0000, "R2 uart off");

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    // Watchdog
    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

endmodule